// File: doc/BRIEF.md
# PHY Link Supervisor and Speed Resolver

This block brings an Ethernet PHY out of reset and then keeps watch over its link. It never drives the serial management lines itself. Every PHY register access goes out as a request on a simple port: request, write flag, register number and write data. The access finishes when a management master returns a one-cycle acknowledge, which on a read carries the register contents. The block sets the MAC's speed and duplex outputs and raises one-cycle link-up and link-down event pulses.

After reset the block sets the PHY's soft-reset bit. It then re-reads the control register until that bit clears and reads the status register. If auto mode is enabled and the PHY says it can negotiate, the block turns negotiation on. If not, it writes a configured forced value and copies that value's speed and duplex bits to the MAC. From then on a free-running timer starts a status read every `POLL_CYCLES` clocks, and only a change of the link bit produces an event. When the link comes up in auto mode, the block waits for negotiation to finish. It then reads the local advertisement and the partner ability, and derives speed and duplex from what both sides offer.

Top module: `phy_link_supervisor`

## Requirements
- R1: While reset is held and afterwards until configured, both MAC outputs and both event outputs are low. The first access after reset is a write of 0x8000 to register 0.
- R2: After the reset write, register 0 is read again and again while its bit 15 reads 1. The first read with bit 15 clear is followed by a read of register 1 (status). A pending request keeps its register number until acknowledged.
- R3: If `autoEnable` is 1 and status bit 3 (can negotiate) is 1, the next access writes 0x1000 (bit 12) to register 0. Otherwise it writes `forcedCtrl` to register 0.
- R4: After a forced write, `macSpeed100` equals `forcedCtrl[13]` and `macFullDuplex` equals `forcedCtrl[8]`.
- R5: Status register bit 2 (link) is read once per poll period. An event fires only when it differs from the last recorded value, each event is a single-cycle pulse, and a steady link produces no further events.
- R6: A recorded change from 1 to 0 gives one `linkDownEvt` pulse. A change from 0 to 1 in forced mode gives one `linkUpEvt` pulse directly after that poll read.
- R7: On a change to link up in auto mode, register 1 is re-read until bit 5 (negotiation done) is 1. Register 4 and then register 5 are read next, and `linkUpEvt` pulses after the register 5 read.
- R8: If a re-read during that wait shows link bit 2 low, the wait ends. `linkUpEvt` still pulses once, registers 4 and 5 are not read, and the MAC outputs keep their values.
- R9: Let C be register 4 AND register 5. The 100 Mb/s output is set when C[8] or C[7] is 1, and full duplex is then C[8]. Otherwise the speed is 10 Mb/s and full duplex is C[6].
- R10: A poll tick that falls while a register sequence is busy is kept. The status read it calls for starts one cycle after the block goes idle again.
- R11: `linkUpEvt` and `linkDownEvt` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| autoEnable | input | 1 | Allow auto-negotiation when the PHY supports it |
| forcedCtrl | input | 16 | Control-register value used in forced mode |
| mgmtReq | output | 1 | Register access request, held until acknowledged |
| mgmtWrite | output | 1 | 1 = write, 0 = read |
| mgmtReg | output | 5 | PHY register number |
| mgmtWdata | output | 16 | Write data |
| mgmtAck | input | 1 | One-cycle completion from the management master |
| mgmtRdata | input | 16 | Read data, valid with `mgmtAck` |
| linkUpEvt | output | 1 | One-cycle pulse on a reported link rise |
| linkDownEvt | output | 1 | One-cycle pulse on a reported link fall |
| macSpeed100 | output | 1 | MAC speed: 1 = 100 Mb/s, 0 = 10 Mb/s |
| macFullDuplex | output | 1 | MAC duplex: 1 = full, 0 = half |

## Verification
Two things can land in the same cycle: the poll timer's tick and the work of a long link-up resolution sequence, including the cycle in which the pending poll is consumed. The bench provokes this by slowing the acknowledge latency so that the negotiation wait and the two ability reads take longer than one poll period. It judges the result by requiring a fresh status-read request exactly one cycle after `linkUpEvt`, which shows the tick was neither lost nor doubled.

// File: rtl/plsv_pkg.sv
package plsv_pkg;

  localparam logic [4:0] REG_CTRL = 5'd0;
  localparam logic [4:0] REG_STAT = 5'd1;
  localparam logic [4:0] REG_ADV  = 5'd4;
  localparam logic [4:0] REG_LPA  = 5'd5;

  localparam logic [15:0] CTRL_RESET  = 16'h8000;
  localparam logic [15:0] CTRL_AN_ON  = 16'h1000;
  localparam int          BIT_SPD100  = 13;
  localparam int          BIT_FDX     = 8;

  typedef enum logic [3:0] {
    ST_RST_WR, ST_RST_RD, ST_CAP_RD, ST_AN_WR, ST_FORCE_WR,
    ST_IDLE, ST_POLL_RD, ST_ANW_RD, ST_ADV_RD, ST_LPA_RD
  } seqState_t;

  typedef struct packed {
    logic startTimer;
    logic consumePoll;
    logic record;
    logic recordVal;
    logic fireUp;
    logic fireDown;
    logic forceApply;
    logic latchAdv;
    logic resolve;
  } strobe_t;

endpackage

// File: rtl/plsv_ctrl.sv
module plsv_ctrl
  import plsv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        autoEnable,
  input  logic [15:0] forcedCtrl,
  input  logic        mgmtAck,
  input  logic        rdResetBit,
  input  logic        rdLink,
  input  logic        rdAnCap,
  input  logic        rdAnDone,
  input  logic        linkRec,
  input  logic        pollDue,
  output logic        mgmtReq,
  output logic        mgmtWrite,
  output logic [4:0]  mgmtReg,
  output logic [15:0] mgmtWdata,
  output strobe_t     st
);

  seqState_t state, stateNext;
  logic autoMode, autoModeNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RST_WR;
      autoMode <= 1'b0;
    end else begin
      state    <= stateNext;
      autoMode <= autoModeNext;
    end
  end

  always_comb begin
    mgmtReq   = 1'b1;
    mgmtWrite = 1'b0;
    mgmtReg   = REG_STAT;
    mgmtWdata = 16'h0000;
    case (state)
      ST_RST_WR:   begin mgmtWrite = 1'b1; mgmtReg = REG_CTRL; mgmtWdata = CTRL_RESET; end
      ST_RST_RD:   mgmtReg = REG_CTRL;
      ST_AN_WR:    begin mgmtWrite = 1'b1; mgmtReg = REG_CTRL; mgmtWdata = CTRL_AN_ON; end
      ST_FORCE_WR: begin mgmtWrite = 1'b1; mgmtReg = REG_CTRL; mgmtWdata = forcedCtrl; end
      ST_ADV_RD:   mgmtReg = REG_ADV;
      ST_LPA_RD:   mgmtReg = REG_LPA;
      ST_IDLE:     mgmtReq = 1'b0;
      default:     mgmtReg = REG_STAT;
    endcase
  end

  always_comb begin
    stateNext    = state;
    autoModeNext = autoMode;
    st           = '0;
    st.recordVal = rdLink;
    case (state)
      ST_RST_WR: if (mgmtAck) stateNext = ST_RST_RD;
      ST_RST_RD: if (mgmtAck && !rdResetBit) stateNext = ST_CAP_RD;
      ST_CAP_RD: if (mgmtAck) stateNext = (autoEnable && rdAnCap) ? ST_AN_WR : ST_FORCE_WR;
      ST_AN_WR: if (mgmtAck) begin
        st.startTimer = 1'b1;
        autoModeNext  = 1'b1;
        stateNext     = ST_IDLE;
      end
      ST_FORCE_WR: if (mgmtAck) begin
        st.startTimer = 1'b1;
        st.forceApply = 1'b1;
        autoModeNext  = 1'b0;
        stateNext     = ST_IDLE;
      end
      ST_IDLE: if (pollDue) begin
        st.consumePoll = 1'b1;
        stateNext      = ST_POLL_RD;
      end
      ST_POLL_RD: if (mgmtAck) begin
        stateNext = ST_IDLE;
        if (rdLink != linkRec) begin
          st.record = 1'b1;
          if (!rdLink)        st.fireDown = 1'b1;
          else if (autoMode)  stateNext   = ST_ANW_RD;
          else                st.fireUp   = 1'b1;
        end
      end
      ST_ANW_RD: if (mgmtAck) begin
        if (!rdLink) begin
          st.fireUp = 1'b1;
          stateNext = ST_IDLE;
        end else if (rdAnDone) begin
          stateNext = ST_ADV_RD;
        end
      end
      ST_ADV_RD: if (mgmtAck) begin
        st.latchAdv = 1'b1;
        stateNext   = ST_LPA_RD;
      end
      ST_LPA_RD: if (mgmtAck) begin
        st.resolve = 1'b1;
        st.fireUp  = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_RST_WR;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mgmtReq && !mgmtAck) |=> (mgmtReq && $stable(mgmtReg))); // R2

endmodule

// File: rtl/plsv_datapath.sv
module plsv_datapath
  import plsv_pkg::*;
#(
  parameter int POLL_CYCLES = 100_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  strobe_t     st,
  input  logic [15:0] mgmtRdata,
  input  logic [15:0] forcedCtrl,
  output logic        linkRec,
  output logic        pollDue,
  output logic        linkUpEvt,
  output logic        linkDownEvt,
  output logic        macSpeed100,
  output logic        macFullDuplex
);

  localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

  logic [CW-1:0] pollCnt;
  logic          running, tick, pending;
  logic [15:0]   advReg, common;
  logic          res100, resFdx;

  assign tick = running && (pollCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pollCnt <= '0;
      running <= 1'b0;
      pollDue <= 1'b0;
    end else begin
      if (st.startTimer) running <= 1'b1;
      if (running) pollCnt <= tick ? '0 : pollCnt + 1'b1;
      pollDue <= tick | (pollDue & ~st.consumePoll);
    end
  end

  assign common = advReg & mgmtRdata;
  assign res100 = common[8] | common[7];
  assign resFdx = res100 ? common[8] : common[6];

  always_ff @(posedge clk) begin
    if (rst) begin
      linkRec       <= 1'b0;
      pending       <= 1'b0;
      advReg        <= '0;
      linkUpEvt     <= 1'b0;
      linkDownEvt   <= 1'b0;
      macSpeed100   <= 1'b0;
      macFullDuplex <= 1'b0;
    end else begin
      linkUpEvt   <= st.fireUp;
      linkDownEvt <= st.fireDown;
      if (st.record) linkRec <= st.recordVal;
      if (st.fireUp || st.fireDown) pending <= 1'b0;
      else if (st.record)          pending <= 1'b1;
      if (st.latchAdv) advReg <= mgmtRdata;
      if (st.forceApply) begin
        macSpeed100   <= forcedCtrl[BIT_SPD100];
        macFullDuplex <= forcedCtrl[BIT_FDX];
      end else if (st.resolve) begin
        macSpeed100   <= res100;
        macFullDuplex <= resFdx;
      end
    end
  end

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(linkUpEvt && linkDownEvt)); // R11
  AST_UP_PULSE: assert property (@(posedge clk) disable iff (rst)
    linkUpEvt |=> !linkUpEvt); // R5
  AST_DOWN_PULSE: assert property (@(posedge clk) disable iff (rst)
    linkDownEvt |=> !linkDownEvt); // R5
  AST_FIRE_PENDING: assert property (@(posedge clk) disable iff (rst)
    (st.fireUp || st.fireDown) |-> (pending || st.record)); // R5
  AST_MAC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(st.resolve || st.forceApply) |=> $stable({macSpeed100, macFullDuplex})); // R8
  AST_TICK_KEEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> pollDue); // R10

endmodule

// File: rtl/phy_link_supervisor.sv
module phy_link_supervisor
  import plsv_pkg::*;
#(
  parameter int POLL_CYCLES = 100_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        autoEnable,
  input  logic [15:0] forcedCtrl,
  output logic        mgmtReq,
  output logic        mgmtWrite,
  output logic [4:0]  mgmtReg,
  output logic [15:0] mgmtWdata,
  input  logic        mgmtAck,
  input  logic [15:0] mgmtRdata,
  output logic        linkUpEvt,
  output logic        linkDownEvt,
  output logic        macSpeed100,
  output logic        macFullDuplex
);

  strobe_t st;
  logic    linkRec, pollDue;

  plsv_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .autoEnable (autoEnable),
    .forcedCtrl (forcedCtrl),
    .mgmtAck    (mgmtAck),
    .rdResetBit (mgmtRdata[15]),
    .rdLink     (mgmtRdata[2]),
    .rdAnCap    (mgmtRdata[3]),
    .rdAnDone   (mgmtRdata[5]),
    .linkRec    (linkRec),
    .pollDue    (pollDue),
    .mgmtReq    (mgmtReq),
    .mgmtWrite  (mgmtWrite),
    .mgmtReg    (mgmtReg),
    .mgmtWdata  (mgmtWdata),
    .st         (st)
  );

  plsv_datapath #(.POLL_CYCLES(POLL_CYCLES)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .st            (st),
    .mgmtRdata     (mgmtRdata),
    .forcedCtrl    (forcedCtrl),
    .linkRec       (linkRec),
    .pollDue       (pollDue),
    .linkUpEvt     (linkUpEvt),
    .linkDownEvt   (linkDownEvt),
    .macSpeed100   (macSpeed100),
    .macFullDuplex (macFullDuplex)
  );

endmodule

// File: tb/phy_link_supervisor_bench.sv
module phy_link_supervisor_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int POLL        = 40;
  localparam int RESET_READS = 2;
  localparam int WATCHDOG    = 50000;

  // adv, lpa, expected 100, expected full duplex
  localparam logic [33:0] VEC [0:5] = '{
    {16'h01E1, 16'h01E1, 1'b1, 1'b1},
    {16'h01E1, 16'h00A1, 1'b1, 1'b0},
    {16'h00E1, 16'h01E1, 1'b1, 1'b0},
    {16'h0161, 16'h0061, 1'b0, 1'b1},
    {16'h0021, 16'h01E1, 1'b0, 1'b0},
    {16'h0101, 16'h0101, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic autoEnable = 1'b0;
  logic [15:0] forcedCtrl = 16'h0000;
  logic mgmtReq, mgmtWrite, mgmtAck;
  logic [4:0] mgmtReg;
  logic [15:0] mgmtWdata, mgmtRdata;
  logic linkUpEvt, linkDownEvt, macSpeed100, macFullDuplex;

  // PHY model knobs, driven by the main sequence only
  logic phyLink = 1'b0, phyAnCap = 1'b1, phyAnDone = 1'b0;
  logic [15:0] phyAdv = 16'h0, phyLpa = 16'h0;
  int ackLat = 1;

  // PHY model state
  int cnt, resetLeft, txCount, rd1Count, rd4Count, rd5Count;
  logic [4:0]  txReg  [0:15];
  logic        txWr   [0:15];
  logic [15:0] txData [0:15];

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_link_supervisor #(.POLL_CYCLES(POLL)) u_phy_link_supervisor (
    .clk(clk), .rst(rst), .autoEnable(autoEnable), .forcedCtrl(forcedCtrl),
    .mgmtReq(mgmtReq), .mgmtWrite(mgmtWrite), .mgmtReg(mgmtReg),
    .mgmtWdata(mgmtWdata), .mgmtAck(mgmtAck), .mgmtRdata(mgmtRdata),
    .linkUpEvt(linkUpEvt), .linkDownEvt(linkDownEvt),
    .macSpeed100(macSpeed100), .macFullDuplex(macFullDuplex)
  );

  always @(posedge clk) begin
    if (rst) begin
      mgmtAck <= 1'b0; mgmtRdata <= 16'h0; cnt <= 0; resetLeft <= 0;
      txCount <= 0; rd1Count <= 0; rd4Count <= 0; rd5Count <= 0;
    end else if (mgmtAck) begin
      mgmtAck <= 1'b0;
    end else if (mgmtReq) begin
      if (cnt >= ackLat) begin
        cnt <= 0;
        mgmtAck <= 1'b1;
        if (txCount < 16) begin
          txReg[txCount] <= mgmtReg; txWr[txCount] <= mgmtWrite; txData[txCount] <= mgmtWdata;
        end
        txCount <= txCount + 1;
        if (mgmtWrite) begin
          if (mgmtReg == 5'd0 && mgmtWdata[15]) resetLeft <= RESET_READS;
          mgmtRdata <= 16'h0;
        end else begin
          case (mgmtReg)
            5'd0: begin
              mgmtRdata <= (resetLeft > 0) ? 16'h8000 : 16'h0000;
              if (resetLeft > 0) resetLeft <= resetLeft - 1;
            end
            5'd1: begin
              mgmtRdata <= {10'b0, phyAnDone, 1'b0, phyAnCap, phyLink, 2'b0};
              rd1Count <= rd1Count + 1;
            end
            5'd4: begin mgmtRdata <= phyAdv; rd4Count <= rd4Count + 1; end
            5'd5: begin mgmtRdata <= phyLpa; rd5Count <= rd5Count + 1; end
            default: mgmtRdata <= 16'h0;
          endcase
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic waitTx(input int n);
    for (int i = 0; i < 500 && txCount < n; i++) @(negedge clk);
  endtask

  task automatic waitEvt(input bit up, input int maxCyc, output bit got);
    got = 0;
    for (int i = 0; i < maxCyc && !got; i++) begin
      @(negedge clk);
      if (up ? linkUpEvt : linkDownEvt) got = 1;
    end
  endtask

  task automatic checkBringup(input logic [15:0] expWr, input string req);
    waitTx(6);
    chk(txWr[0] && txReg[0] == 0 && txData[0] == 16'h8000, "R1", txData[0], 16'h8000);
    for (int i = 1; i <= RESET_READS + 1; i++)
      chk(!txWr[i] && txReg[i] == 0, "R2", txReg[i], 0);
    chk(!txWr[4] && txReg[4] == 1, "R2", txReg[4], 1);
    chk(txWr[5] && txReg[5] == 0 && txData[5] == expWr, req, txData[5], expWr);
  endtask

  initial begin
    bit got;
    int evts, r4, r5, r1;
    // ---- phase A: forced mode ----
    autoEnable = 1'b0; forcedCtrl = 16'h2100; phyAnCap = 1'b1;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk({macSpeed100, macFullDuplex, linkUpEvt, linkDownEvt} == 4'b0, "R1",
        {macSpeed100, macFullDuplex, linkUpEvt, linkDownEvt}, 0);
    rst = 1'b0;
    checkBringup(16'h2100, "R3");
    repeat (2) @(negedge clk);
    chk(macSpeed100 == 1'b1 && macFullDuplex == 1'b1, "R4", {macSpeed100, macFullDuplex}, 2'b11);
    phyLink = 1'b1;
    waitEvt(1, 200, got);
    chk(got, "R6", got, 1);
    @(negedge clk);
    chk(!linkUpEvt, "R5", linkUpEvt, 0);
    evts = 0;
    for (int i = 0; i < 4 * POLL; i++) begin
      @(negedge clk);
      if (linkUpEvt || linkDownEvt) evts++;
    end
    chk(evts == 0, "R5", evts, 0);
    phyLink = 1'b0;
    waitEvt(0, 200, got);
    chk(got, "R6", got, 1);
    @(negedge clk);
    chk(!linkDownEvt, "R5", linkDownEvt, 0);

    // ---- phase B: auto mode, resolution table ----
    autoEnable = 1'b1; phyAnCap = 1'b1; phyAnDone = 1'b1;
    doReset();
    checkBringup(16'h1000, "R3");
    foreach (VEC[k]) begin
      phyAdv = VEC[k][33:18]; phyLpa = VEC[k][17:2];
      r4 = rd4Count; r5 = rd5Count;
      phyLink = 1'b1;
      waitEvt(1, 300, got);
      chk(got, "R7", got, 1);
      chk(rd4Count == r4 + 1 && rd5Count == r5 + 1, "R7", rd5Count - r5, 1);
      chk(macSpeed100 == VEC[k][1] && macFullDuplex == VEC[k][0], "R9",
          {macSpeed100, macFullDuplex}, VEC[k][1:0]);
      phyLink = 1'b0;
      waitEvt(0, 300, got);
      chk(got, "R6", got, 1);
    end

    // R8: link drops while waiting for negotiation
    phyAnDone = 1'b0; phyAdv = 16'h0021; phyLpa = 16'h0021;
    r1 = rd1Count; r4 = rd4Count;
    phyLink = 1'b1;
    for (int i = 0; i < 300 && rd1Count < r1 + 3; i++) @(negedge clk);
    phyLink = 1'b0;
    waitEvt(1, 300, got);
    chk(got, "R8", got, 1);
    chk(rd4Count == r4, "R8", rd4Count - r4, 0);
    chk(macSpeed100 == 1'b1 && macFullDuplex == 1'b1, "R8", {macSpeed100, macFullDuplex}, 2'b11);
    waitEvt(0, 300, got);
    chk(got, "R8", got, 1);

    // R10: poll tick lands during a slow resolution sequence
    phyAnDone = 1'b1; phyAdv = 16'h0041; phyLpa = 16'h0041;
    ackLat = 30;
    phyLink = 1'b1;
    waitEvt(1, 2000, got);
    chk(got, "R10", got, 1);
    chk(macSpeed100 == 1'b0 && macFullDuplex == 1'b1, "R9", {macSpeed100, macFullDuplex}, 2'b01);
    @(negedge clk);
    chk(mgmtReq && !mgmtWrite && mgmtReg == 5'd1, "R10", {mgmtReq, mgmtReg}, 6'h21);
    ackLat = 1;
    phyLink = 1'b0;

    // ---- phase C: auto requested, PHY cannot negotiate ----
    autoEnable = 1'b1; phyAnCap = 1'b0; forcedCtrl = 16'h0100;
    doReset();
    checkBringup(16'h0100, "R3");
    repeat (2) @(negedge clk);
    chk(macSpeed100 == 1'b0 && macFullDuplex == 1'b1, "R4", {macSpeed100, macFullDuplex}, 2'b01);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      summary();
      $finish;
    end
  end

endmodule